// File: doc/BRIEF.md
# Asynchronous Static Memory Strobe Sequencer

This block sits between a simple clocked host port and an external asynchronous static memory with separate data-in and data-out pins. The host raises a one-cycle request with a direction, an address and write data. The sequencer then drives the memory's address, data-in, active-low select, active-high select, output-off control and active-low write strobe. Each phase is held for a whole number of clock cycles, so that every minimum interval the memory needs is met. Read data is sampled once the access time has passed. Every access ends with a single-cycle completion pulse, and a read also returns its data at that point.

The intervals are given in nanoseconds, for a fast and a slow speed grade. They are turned into cycle counts at elaboration time from a clock-period parameter, always rounding up. There is also a low-power retention mode. On entry the active-high select is held low for a guard time. After that the block reports that the supply may be lowered. On wake-up the same guard time passes before any normal access can start.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: During and right after a synchronous reset, mem_sel_n=1, mem_sel=1, mem_oe_off=1, mem_wr_n=1, host_done=0 and retain=0.
- R2: Every interval is ceil(ns / CLK_PERIOD_NS) cycles, with a minimum of 1. Fast grade (SLOW_GRADE=0) uses access 250, cycle 250, address setup 110, output-off setup 110, strobe width 150, data setup 150, recovery 40 and write cycle 300 ns. Slow grade uses 350, 350, 150, 150, 200, 200, 50 and 400 ns. The retention guard is 600 ns in both grades.
- R3: On a read request accepted in idle (host_we=0), mem_sel_n=0, mem_sel=1, mem_oe_off=0 and mem_wr_n=1 are held for RD = max(access, cycle) cycles with a stable address. mem_do is sampled at the end of the last of these cycles. In the next cycle the selects are released, host_done=1 and host_rdata holds the sampled word.
- R4: On a write request, mem_a and mem_di carry the request, mem_sel_n=0 and mem_oe_off=1 are held for SET = max(address setup, output-off setup) cycles with mem_wr_n=1 before the strobe falls. The output-off setup is counted only when SHARED_BUS=1.
- R5: mem_wr_n stays low for PUL = max(strobe width, data setup) cycles. Throughout, the selects are active and mem_a and mem_di are stable.
- R6: After mem_wr_n rises, the selects, mem_a and mem_di are held for REC = max(recovery, write cycle − SET − PUL) cycles. host_done is then 1 for one cycle, in the same cycle the selects are released.
- R7: host_done is never high for two consecutive cycles. Requests that arrive while an access is in progress are ignored: they cause no pin activity and no extra host_done.
- R8: A sleep_req seen in idle without host_req holds mem_sel=0 and mem_sel_n=1 for SBY = ceil(600 / CLK_PERIOD_NS) cycles. After that, retain=1 for as long as retention lasts, with mem_sel=0 and mem_sel_n=1.
- R9: During retention, host_req is ignored. A wake_req clears retain and keeps mem_sel=0 for a further SBY cycles, after which mem_sel returns to 1 and the block is idle.
- R10: When host_req and sleep_req are both high in the same idle cycle, the access is performed and the sleep request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | One-cycle access request, taken only when idle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | AW | Access address |
| host_wdata | input | DW | Write data |
| sleep_req | input | 1 | Request to enter retention, taken only when idle |
| wake_req | input | 1 | Request to leave retention |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | DW | Read data, valid with host_done after a read |
| retain | output | 1 | Retention active; the supply may be lowered |
| mem_a | output | AW | Memory address |
| mem_di | output | DW | Memory data in |
| mem_do | input | DW | Memory data out |
| mem_sel_n | output | 1 | Active-low memory select |
| mem_sel | output | 1 | Active-high memory select, also the retention guard |
| mem_oe_off | output | 1 | 1 forces the memory output off |
| mem_wr_n | output | 1 | Active-low write strobe |

## Verification
Two collisions can land on the same sampling edge. One is a host access request arriving together with a sleep request in idle. The other is a host access request arriving together with the wake request during retention. The bench raises both inputs on the same negative edge. In the first case it requires a full, correctly timed access followed by an idle bus with retain low. In the second it requires an exact guard period with no select activity and no completion pulse. Besides this, a memory model returns inverted data until the access time has elapsed, which exposes any early capture.

// File: rtl/sram_strobe_pkg.sv
package sram_strobe_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RD_ACCESS,
    S_RD_DONE,
    S_WR_SETUP,
    S_WR_PULSE,
    S_WR_RECOVER,
    S_STBY_ENTER,
    S_STBY,
    S_STBY_EXIT
  } seq_state_e;

  // Round a nanosecond interval up to whole cycles, never below one.
  function automatic int ns_to_cyc(input int ns, input int per);
    int c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_interval_timer.sv
module sram_interval_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_strobe_pkg::*;
#(
  parameter int CNT_W   = 6,
  parameter int RD_CYC  = 13,
  parameter int SET_CYC = 6,
  parameter int PUL_CYC = 8,
  parameter int REC_CYC = 2,
  parameter int SBY_CYC = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_req,
  input  logic             host_we,
  input  logic             sleep_req,
  input  logic             wake_req,
  input  logic             tmr_zero,
  output seq_state_e       state_nxt,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             capture,
  output logic             finish
);

  localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] SET_LD = CNT_W'(SET_CYC - 1);
  localparam logic [CNT_W-1:0] PUL_LD = CNT_W'(PUL_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LD = CNT_W'(REC_CYC - 1);
  localparam logic [CNT_W-1:0] SBY_LD = CNT_W'(SBY_CYC - 1);

  seq_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) state_q <= S_IDLE;
    else     state_q <= state_nxt;
  end

  always_comb begin
    state_nxt = state_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    accept    = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (host_req) begin
          accept    = 1'b1;
          tmr_load  = 1'b1;
          state_nxt = host_we ? S_WR_SETUP : S_RD_ACCESS;
          tmr_val   = host_we ? SET_LD : RD_LD;
        end else if (sleep_req) begin
          tmr_load  = 1'b1;
          tmr_val   = SBY_LD;
          state_nxt = S_STBY_ENTER;
        end
      end
      S_RD_ACCESS:  if (tmr_zero) state_nxt = S_RD_DONE;
      S_RD_DONE:    state_nxt = S_IDLE;
      S_WR_SETUP: begin
        if (tmr_zero) begin
          state_nxt = S_WR_PULSE;
          tmr_load  = 1'b1;
          tmr_val   = PUL_LD;
        end
      end
      S_WR_PULSE: begin
        if (tmr_zero) begin
          state_nxt = S_WR_RECOVER;
          tmr_load  = 1'b1;
          tmr_val   = REC_LD;
        end
      end
      S_WR_RECOVER: if (tmr_zero) state_nxt = S_IDLE;
      S_STBY_ENTER: if (tmr_zero) state_nxt = S_STBY;
      S_STBY: begin
        if (wake_req) begin
          state_nxt = S_STBY_EXIT;
          tmr_load  = 1'b1;
          tmr_val   = SBY_LD;
        end
      end
      S_STBY_EXIT:  if (tmr_zero) state_nxt = S_IDLE;
      default:      state_nxt = S_IDLE;
    endcase
  end

  assign capture = (state_q == S_RD_ACCESS) && tmr_zero;
  assign finish  = capture || ((state_q == S_WR_RECOVER) && tmr_zero);

endmodule

// File: rtl/sram_pin_regs.sv
module sram_pin_regs
  import sram_strobe_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  seq_state_e    state_nxt,
  input  logic          accept,
  input  logic          capture,
  input  logic          finish,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic [DW-1:0] mem_do,
  output logic [AW-1:0] mem_a,
  output logic [DW-1:0] mem_di,
  output logic          mem_sel_n,
  output logic          mem_sel,
  output logic          mem_oe_off,
  output logic          mem_wr_n,
  output logic          retain,
  output logic          host_done,
  output logic [DW-1:0] host_rdata
);

  // Pin levels decoded from the next state, then registered, so the pins
  // change on the same edge as the state and never glitch.
  logic sel_n_d, sel_d, oe_off_d, wr_n_d, retain_d;

  always_comb begin
    sel_n_d  = 1'b1;
    sel_d    = 1'b1;
    oe_off_d = 1'b1;
    wr_n_d   = 1'b1;
    retain_d = 1'b0;
    unique case (state_nxt)
      S_RD_ACCESS: begin
        sel_n_d  = 1'b0;
        oe_off_d = 1'b0;
      end
      S_WR_SETUP, S_WR_RECOVER: sel_n_d = 1'b0;
      S_WR_PULSE: begin
        sel_n_d = 1'b0;
        wr_n_d  = 1'b0;
      end
      S_STBY_ENTER, S_STBY_EXIT: sel_d = 1'b0;
      S_STBY: begin
        sel_d    = 1'b0;
        retain_d = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_a      <= '0;
      mem_di     <= '0;
      mem_sel_n  <= 1'b1;
      mem_sel    <= 1'b1;
      mem_oe_off <= 1'b1;
      mem_wr_n   <= 1'b1;
      retain     <= 1'b0;
      host_done  <= 1'b0;
      host_rdata <= '0;
    end else begin
      mem_sel_n  <= sel_n_d;
      mem_sel    <= sel_d;
      mem_oe_off <= oe_off_d;
      mem_wr_n   <= wr_n_d;
      retain     <= retain_d;
      host_done  <= finish;
      if (accept) begin
        mem_a  <= host_addr;
        mem_di <= host_wdata;
      end
      if (capture) host_rdata <= mem_do;
    end
  end

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_strobe_pkg::*;
#(
  parameter int AW            = 8,
  parameter int DW            = 4,
  parameter int CLK_PERIOD_NS = 20,
  parameter int SLOW_GRADE    = 0,
  parameter int SHARED_BUS    = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_req,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic          sleep_req,
  input  logic          wake_req,
  output logic          host_done,
  output logic [DW-1:0] host_rdata,
  output logic          retain,
  output logic [AW-1:0] mem_a,
  output logic [DW-1:0] mem_di,
  input  logic [DW-1:0] mem_do,
  output logic          mem_sel_n,
  output logic          mem_sel,
  output logic          mem_oe_off,
  output logic          mem_wr_n
);

  // Nanosecond minimums per speed grade
  localparam int ACC_NS   = (SLOW_GRADE != 0) ? 350 : 250;
  localparam int RCYC_NS  = (SLOW_GRADE != 0) ? 350 : 250;
  localparam int ASU_NS   = (SLOW_GRADE != 0) ? 150 : 110;
  localparam int OSU_NS   = (SLOW_GRADE != 0) ? 150 : 110;
  localparam int WW_NS    = (SLOW_GRADE != 0) ? 200 : 150;
  localparam int DSU_NS   = (SLOW_GRADE != 0) ? 200 : 150;
  localparam int WREC_NS  = (SLOW_GRADE != 0) ? 50  : 40;
  localparam int WCYC_NS  = (SLOW_GRADE != 0) ? 400 : 300;
  localparam int GUARD_NS = 600;

  // Cycle counts
  localparam int RD_CYC  = imax(ns_to_cyc(ACC_NS, CLK_PERIOD_NS),
                                ns_to_cyc(RCYC_NS, CLK_PERIOD_NS));
  localparam int OSU_CYC = (SHARED_BUS != 0) ? ns_to_cyc(OSU_NS, CLK_PERIOD_NS) : 1;
  localparam int SET_CYC = imax(ns_to_cyc(ASU_NS, CLK_PERIOD_NS), OSU_CYC);
  localparam int PUL_CYC = imax(ns_to_cyc(WW_NS, CLK_PERIOD_NS),
                                ns_to_cyc(DSU_NS, CLK_PERIOD_NS));
  localparam int REC_CYC = imax(ns_to_cyc(WREC_NS, CLK_PERIOD_NS),
                                ns_to_cyc(WCYC_NS, CLK_PERIOD_NS) - SET_CYC - PUL_CYC);
  localparam int SBY_CYC = ns_to_cyc(GUARD_NS, CLK_PERIOD_NS);
  localparam int MAX_CYC = imax(imax(RD_CYC, SBY_CYC),
                                imax(SET_CYC, imax(PUL_CYC, REC_CYC)));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  seq_state_e       state_nxt;
  logic             tmr_load, tmr_zero, accept, capture, finish;
  logic [CNT_W-1:0] tmr_val;

  sram_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  sram_seq_fsm #(
    .CNT_W   (CNT_W),
    .RD_CYC  (RD_CYC),
    .SET_CYC (SET_CYC),
    .PUL_CYC (PUL_CYC),
    .REC_CYC (REC_CYC),
    .SBY_CYC (SBY_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .host_req  (host_req),
    .host_we   (host_we),
    .sleep_req (sleep_req),
    .wake_req  (wake_req),
    .tmr_zero  (tmr_zero),
    .state_nxt (state_nxt),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .accept    (accept),
    .capture   (capture),
    .finish    (finish)
  );

  sram_pin_regs #(.AW(AW), .DW(DW)) u_pins (
    .clk        (clk),
    .rst        (rst),
    .state_nxt  (state_nxt),
    .accept     (accept),
    .capture    (capture),
    .finish     (finish),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .mem_do     (mem_do),
    .mem_a      (mem_a),
    .mem_di     (mem_di),
    .mem_sel_n  (mem_sel_n),
    .mem_sel    (mem_sel),
    .mem_oe_off (mem_oe_off),
    .mem_wr_n   (mem_wr_n),
    .retain     (retain),
    .host_done  (host_done),
    .host_rdata (host_rdata)
  );

endmodule

// File: rtl/sram_strobe_chk.sv
module sram_strobe_chk
  import sram_strobe_pkg::*;
#(
  parameter int AW            = 8,
  parameter int DW            = 4,
  parameter int CLK_PERIOD_NS = 20,
  parameter int SLOW_GRADE    = 0
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] mem_a,
  input logic [DW-1:0] mem_di,
  input logic          mem_sel_n,
  input logic          mem_sel,
  input logic          mem_oe_off,
  input logic          mem_wr_n,
  input logic          retain,
  input logic          host_done
);

  // Bare datasheet minimums, independent of how the sequencer folds them
  localparam int ASU_MIN = ns_to_cyc((SLOW_GRADE != 0) ? 150 : 110, CLK_PERIOD_NS);
  localparam int WW_MIN  = ns_to_cyc((SLOW_GRADE != 0) ? 200 : 150, CLK_PERIOD_NS);

  logic [15:0] setup_cnt, low_cnt;

  always_ff @(posedge clk) begin
    if (rst || mem_sel_n) setup_cnt <= '0;
    else if (mem_wr_n && setup_cnt != 16'hFFFF) setup_cnt <= setup_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || mem_wr_n) low_cnt <= '0;
    else if (low_cnt != 16'hFFFF) low_cnt <= low_cnt + 1'b1;
  end

  p_setup_min_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_wr_n) |-> (setup_cnt >= 16'(ASU_MIN)));

  p_pulse_min_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_wr_n) |-> (low_cnt >= 16'(WW_MIN)));

  p_strobe_selected_r5: assert property (@(posedge clk) disable iff (rst)
    !mem_wr_n |-> (!mem_sel_n && mem_sel && mem_oe_off));

  p_pulse_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (!mem_wr_n && $past(!mem_wr_n)) |-> ($stable(mem_a) && $stable(mem_di)));

  p_hold_after_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_wr_n) |-> (!mem_sel_n && $stable(mem_a) && $stable(mem_di)));

  p_read_no_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_off |-> (mem_wr_n && !mem_sel_n));

  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    host_done |=> !host_done);

  p_retain_guard_r8: assert property (@(posedge clk) disable iff (rst)
    retain |-> (mem_sel_n && !mem_sel));

endmodule

bind sram_strobe_ctrl sram_strobe_chk #(
  .AW            (AW),
  .DW            (DW),
  .CLK_PERIOD_NS (CLK_PERIOD_NS),
  .SLOW_GRADE    (SLOW_GRADE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mem_a      (mem_a),
  .mem_di     (mem_di),
  .mem_sel_n  (mem_sel_n),
  .mem_sel    (mem_sel),
  .mem_oe_off (mem_oe_off),
  .mem_wr_n   (mem_wr_n),
  .retain     (retain),
  .host_done  (host_done)
);

// File: tb/sram_strobe_ctrl_bench.sv
module sram_strobe_ctrl_bench;

  localparam int AW  = 8;
  localparam int DW  = 4;
  localparam int PER = 20;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + PER - 1) / PER;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Expected cycle counts, fast grade, shared bus (R2)
  localparam int E_RD  = mx(cyc(250), cyc(250));
  localparam int E_SET = mx(cyc(110), cyc(110));
  localparam int E_PUL = mx(cyc(150), cyc(150));
  localparam int E_REC = mx(cyc(40), cyc(300) - E_SET - E_PUL);
  localparam int E_SBY = cyc(600);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_req = 1'b0, host_we = 1'b0, sleep_req = 1'b0, wake_req = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic host_done, retain, mem_sel_n, mem_sel, mem_oe_off, mem_wr_n;
  logic [DW-1:0] host_rdata, mem_di, mem_do;
  logic [AW-1:0] mem_a;

  int checks = 0;
  int errors = 0;

  always #(PER/2) clk = ~clk;

  sram_strobe_ctrl #(.AW(AW), .DW(DW), .CLK_PERIOD_NS(PER)) u_sram_strobe_ctrl (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .sleep_req(sleep_req),
    .wake_req(wake_req), .host_done(host_done), .host_rdata(host_rdata),
    .retain(retain), .mem_a(mem_a), .mem_di(mem_di), .mem_do(mem_do),
    .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_oe_off(mem_oe_off),
    .mem_wr_n(mem_wr_n)
  );

  // Memory model: data out turns valid only after 250 ns of stable read setup
  logic [DW-1:0] mem [0:(1<<AW)-1];
  logic [DW-1:0] shadow [0:(1<<AW)-1];
  int rd_age = 0;
  logic [AW-1:0] age_addr = '0;
  logic rd_cfg;
  assign rd_cfg = (mem_sel_n === 1'b0) && (mem_sel === 1'b1) &&
                  (mem_oe_off === 1'b0) && (mem_wr_n === 1'b1);
  assign mem_do = (rd_cfg && rd_age * PER >= 250) ? mem[mem_a] : ~mem[mem_a];

  always @(negedge clk) begin
    if (rd_cfg && rd_age != 0 && mem_a == age_addr) rd_age <= rd_age + 1;
    else if (rd_cfg) begin rd_age <= 1; age_addr <= mem_a; end
    else rd_age <= 0;
  end

  always @(posedge mem_wr_n) begin
    if (mem_sel_n === 1'b0 && mem_sel === 1'b1) mem[mem_a] <= mem_di;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit poke);
    int ns_ = 0, np = 0, nr = 0;
    bit bad = 0, early = 0, fin = 0;
    @(negedge clk);
    host_req = 1; host_we = 1; host_addr = a; host_wdata = d;
    for (int i = 0; i < 100 && !fin; i++) begin
      @(negedge clk);
      if (mem_sel_n == 1'b0) begin
        if (host_done) early = 1;
        if (mem_a != a || mem_di != d || !mem_oe_off || !mem_sel) bad = 1;
        if (!mem_wr_n) np++;
        else if (np == 0) ns_++;
        else nr++;
      end else begin
        fin = 1;
        chk(host_done == 1'b1, "R6 done after recovery", int'(host_done), 1);
      end
      host_req = (poke && i == 3);
      host_we = 0; host_addr = ~a;
    end
    host_req = 0;
    chk(ns_ == E_SET, "R4 setup cycles", ns_, E_SET);
    chk(np == E_PUL, "R5 strobe cycles", np, E_PUL);
    chk(nr == E_REC, "R6 recovery cycles", nr, E_REC);
    chk(!bad, "R5 address/data held", int'(bad), 0);
    chk(!early, "R7 no early done", int'(early), 0);
    @(negedge clk);
    chk(!host_done && mem_sel_n, "R7 busy request ignored", int'(host_done), 0);
    shadow[a] = d;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input bit poke, input bit with_sleep);
    int na = 0;
    bit bad = 0, fin = 0;
    @(negedge clk);
    host_req = 1; host_we = 0; host_addr = a; sleep_req = with_sleep;
    for (int i = 0; i < 100 && !fin; i++) begin
      @(negedge clk);
      if (mem_sel_n == 1'b0) begin
        if (host_done || mem_a != a || !mem_wr_n || mem_oe_off) bad = 1;
        na++;
      end else begin
        fin = 1;
        chk(host_done == 1'b1, "R3 done", int'(host_done), 1);
        chk(host_rdata == shadow[a], "R3 read data", int'(host_rdata), int'(shadow[a]));
      end
      sleep_req = 0;
      host_req = (poke && i == 2);
      host_we = 1; host_addr = ~a;
    end
    host_req = 0;
    chk(na == E_RD, "R3 access cycles", na, E_RD);
    chk(!bad, "R3 read pins", int'(bad), 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(mem_sel && !retain && mem_sel_n && !host_done,
          with_sleep ? "R10 sleep dropped" : "R7 no extra access", int'(retain), 0);
    end
  endtask

  initial begin
    #(PER * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd4242));
    for (int a = 0; a < (1 << AW); a++) begin
      mem[a] = DW'(a) ^ 4'h5;
      shadow[a] = DW'(a) ^ 4'h5;
    end
    repeat (4) @(negedge clk);
    chk(mem_sel_n && mem_sel && mem_oe_off && mem_wr_n && !host_done && !retain,
        "R1 pins during reset", int'(mem_wr_n), 1);
    rst = 0;
    @(negedge clk);
    chk(mem_sel_n && mem_sel && mem_oe_off && mem_wr_n && !host_done && !retain,
        "R1 pins after reset", int'(mem_sel_n), 1);

    // R2/R3 read of initial contents, R4-R6 write, R7 busy pokes
    do_read(8'h00, 0, 0);
    do_write(8'h3C, 4'hA, 0);
    do_read(8'h3C, 1, 0);
    do_write(8'hFF, 4'h0, 1);
    do_write(8'hFF, 4'hF, 0);
    do_read(8'hFF, 0, 0);

    // R10 collision of access and sleep
    do_read(8'h3C, 0, 1);

    // R8 standby entry
    @(negedge clk); sleep_req = 1;
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); sleep_req = 0;
      if (retain) break;
      if (!mem_sel && mem_sel_n) n++;
    end
    chk(n == E_SBY, "R8 entry guard cycles", n, E_SBY);
    chk(retain && !mem_sel, "R8 retain asserted", int'(retain), 1);
    // R9 requests ignored in retention
    host_req = 1; host_we = 1; host_addr = 8'h11;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(retain && !mem_sel && mem_sel_n && !host_done, "R9 request ignored", int'(retain), 1);
    end
    // R9 wake collides with request
    wake_req = 1;
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); wake_req = 0; host_req = 0;
      if (mem_sel) break;
      if (!retain && mem_sel_n) n++;
    end
    chk(n == E_SBY, "R9 exit guard cycles", n, E_SBY);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(mem_sel && mem_sel_n && !host_done && !retain, "R9 idle after wake", int'(host_done), 0);
    end

    // Random mix
    for (int i = 0; i < 60; i++) begin
      logic [AW-1:0] ra;
      ra = AW'($urandom % 16);
      if ($urandom % 2) do_write(ra, DW'($urandom), 0);
      else do_read(ra, ($urandom % 4) == 0, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule